// File: doc/BRIEF.md
# Command Ring Consumer with Sticky Error Tracking

This block is the consumer side of a command ring that software keeps in memory. The ring holds a power-of-two number of entries, and software chooses that number at run time. Software fills entries and advances the producer pointer through a register write port. While the enable bit in the control register is set and the ring holds work, the block works out the memory address of the entry at the consumer pointer. It reads the entry's four 32-bit words one at a time over a simple request/response memory port, checks the opcode and presents the decoded command on a valid/ready output. Each accepted command advances the consumer pointer by one.

Each pointer is an index of runtime width with one extra wrap bit directly above it, so a full ring and an empty ring can be told apart. The consumer register also holds a 7-bit sticky error field. An unsupported opcode or a failed memory read writes an error code into that field, and consumption halts with the consumer pointer still on the faulting entry. Software resumes consumption by rewriting the consumer register with the field cleared. Executing the commands is left to the logic downstream of the command output.

Top module: `cmd_ring_ctrl`

## Requirements
- R1: After reset the producer register, the consumer register and its error field read zero, `ring_empty` is 1, `ring_full` is 0, and neither `mem_req_valid` nor `cmd_valid` is asserted.
- R2: `ring_empty` is 1 exactly when producer and consumer agree in their low L+1 bits, where L is the effective ring size exponent. Bits above L are ignored.
- R3: `ring_full` is 1 exactly when producer and consumer, taken to their low L+1 bits, differ only in bit L (the wrap bit).
- R4: The entry address is (base register AND 0xFFFFFFFFFFFC0) + 16 × (consumer AND (2^L − 1)). The four words of an entry are requested in order at offsets 0, 4, 8 and 12 from it.
- R5: No memory request is issued while bit 3 of the control register is clear. Other control bits do not enable fetching.
- R6: A command is presented with `cmd_opcode` = word 0 bits 7:0 and `cmd_words` holding word k at bits 32k+31:32k. It stays valid and unchanged until `cmd_ready`. `cmd_sync` = word 0 bits 13:12 when the opcode is 0x46 (sync: 0 none, 1 interrupt, 2 event) and 0 for every other opcode.
- R7: When a command is accepted, only consumer bits L:0 change, incrementing modulo 2^(L+1). All higher bits, including the error field, keep their values.
- R8: An opcode outside the supported set (0x01–0x07, 0x10–0x13, 0x18, 0x1A, 0x20–0x23, 0x28, 0x2A, 0x30, 0x40, 0x41, 0x44–0x46), or a sync command whose bits 13:12 are 3, writes code 1 into consumer bits 30:24. No command is presented, the pointer does not advance, and no further fetch is made.
- R9: A memory response with `mem_rsp_err` set writes code 2 into consumer bits 30:24. Fetching stops, no command is presented and the pointer does not advance.
- R10: Writing the consumer register with bits 30:24 zero resumes consumption from the written pointer.
- R11: The base register holds L in bits 4:0 and the address in bits 51:6. A value of L above MAX_LOG2 is clamped to MAX_LOG2, and the read-back of the base register returns the clamped L with bit 5 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 base, 1 producer, 2 consumer, 3 control |
| reg_wdata | input | 64 | Write data |
| rd_sel | input | 2 | Read select, same encoding as reg_sel |
| rd_data | output | 64 | Selected register value |
| ring_empty | output | 1 | Ring holds no entries |
| ring_full | output | 1 | Ring holds 2^L entries |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned word |
| mem_rsp_err | input | 1 | Read failed |
| cmd_valid | output | 1 | Decoded command available |
| cmd_ready | input | 1 | Consumer of commands accepts it |
| cmd_opcode | output | 8 | Command opcode |
| cmd_sync | output | 2 | Completion signal of a sync command |
| cmd_words | output | 32×ENTRY_WORDS | Raw command words |

## Verification
The assertions assume that memory returns at most one response for each accepted request, and only while the block is waiting for one. They also assume that software changes registers only while the block is idle. Their pointer and halt properties therefore exclude any cycle with a register write. The bench's memory model answers every request exactly one cycle after it is accepted. The bench writes ring registers only while the control enable is clear or the block has halted on an error or an empty ring.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

   localparam int unsigned ERR_LSB      = 24;
   localparam int unsigned ERR_W        = 7;
   localparam int unsigned CTRL_EN_BIT  = 3;
   localparam logic [7:0]  OP_SYNC      = 8'h46;

   typedef enum logic [ERR_W-1:0] {
      CERR_NONE     = 7'd0,
      CERR_ILLEGAL  = 7'd1,
      CERR_ABORT    = 7'd2,
      CERR_ATC_SYNC = 7'd3
   } cerr_e;

   typedef enum logic [1:0] {
      RSEL_BASE = 2'd0,
      RSEL_PROD = 2'd1,
      RSEL_CONS = 2'd2,
      RSEL_CTRL = 2'd3
   } rsel_e;

   function automatic logic op_supported(input logic [7:0] op);
      logic ok;
      case (op)
         8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
         8'h10, 8'h11, 8'h12, 8'h13, 8'h18, 8'h1A,
         8'h20, 8'h21, 8'h22, 8'h23, 8'h28, 8'h2A, 8'h30,
         8'h40, 8'h41, 8'h44, 8'h45, 8'h46: ok = 1'b1;
         default:                           ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/cr_regs.sv
module cr_regs
   import cmd_ring_pkg::*;
#(
   parameter int unsigned MAX_LOG2    = 4,
   parameter int unsigned ADDR_W      = 52,
   parameter int unsigned ENTRY_SHIFT = 4,
   localparam int unsigned LGW        = $clog2(MAX_LOG2 + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [63:0]       reg_wdata,
   input  logic [1:0]        rd_sel,
   output logic [63:0]       rd_data,
   input  logic              cons_inc,
   input  logic              err_set,
   input  cerr_e             err_code_in,
   output logic [31:0]       prod_q,
   output logic [31:0]       cons_q,
   output logic [31:0]       wi_mask,
   output logic              ctrl_en,
   output logic [ERR_W-1:0]  err_code,
   output logic              ring_empty,
   output logic              ring_full,
   output logic [ADDR_W-1:0] entry_addr
);

   logic [ADDR_W-7:0] base_q;
   logic [4:0]        lg_raw_q;
   logic [31:0]       ctrl_q;
   logic [LGW-1:0]    lg;
   logic [31:0]       lg32;
   logic [31:0]       idx_mask;
   logic [31:0]       diff;
   logic [31:0]       cons_bumped;

   wire unused_wdata_bits = ^{reg_wdata[63:ADDR_W], reg_wdata[5]};

   assign lg   = (lg_raw_q > 5'(MAX_LOG2)) ? LGW'(MAX_LOG2) : LGW'(lg_raw_q);
   assign lg32 = 32'(lg);

   // Masks for the live index bits and index-plus-wrap bits.
   for (genvar i = 0; i < 32; i++) begin : g_mask
      if (i <= MAX_LOG2) begin : g_live
         assign wi_mask[i]  = (lg32 >= 32'(i));
         assign idx_mask[i] = (lg32 >  32'(i));
      end else begin : g_dead
         assign wi_mask[i]  = 1'b0;
         assign idx_mask[i] = 1'b0;
      end
   end

   assign diff        = (prod_q ^ cons_q) & wi_mask;
   assign ring_empty  = (diff == 32'd0);
   assign ring_full   = (diff == (wi_mask ^ idx_mask));
   assign cons_bumped = (cons_q & ~wi_mask) | ((cons_q + 32'd1) & wi_mask);
   assign entry_addr  = {base_q, 6'b0}
                      + (ADDR_W'(cons_q & idx_mask) << ENTRY_SHIFT);
   assign ctrl_en     = ctrl_q[CTRL_EN_BIT];
   assign err_code    = cons_q[ERR_LSB +: ERR_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q   <= '0;
         lg_raw_q <= '0;
         prod_q   <= '0;
         cons_q   <= '0;
         ctrl_q   <= '0;
      end else begin
         if (reg_we && reg_sel == RSEL_BASE) begin
            base_q   <= reg_wdata[ADDR_W-1:6];
            lg_raw_q <= reg_wdata[4:0];
         end
         if (reg_we && reg_sel == RSEL_PROD) prod_q <= reg_wdata[31:0];
         if (reg_we && reg_sel == RSEL_CTRL) ctrl_q <= reg_wdata[31:0];
         // Software write wins over any hardware update of the consumer.
         if (reg_we && reg_sel == RSEL_CONS)
            cons_q <= reg_wdata[31:0];
         else if (err_set)
            cons_q[ERR_LSB +: ERR_W] <= err_code_in;
         else if (cons_inc)
            cons_q <= cons_bumped;
      end
   end

   always_comb begin
      unique case (rsel_e'(rd_sel))
         RSEL_BASE: rd_data = 64'({base_q, 1'b0, 5'(lg)});
         RSEL_PROD: rd_data = 64'(prod_q);
         RSEL_CONS: rd_data = 64'(cons_q);
         RSEL_CTRL: rd_data = 64'(ctrl_q);
         default:   rd_data = 64'(unused_wdata_bits & 1'b0);
      endcase
   end

endmodule

// File: rtl/cr_decode.sv
module cr_decode
   import cmd_ring_pkg::*;
#(
   parameter bit STRICT_SYNC = 1'b1
) (
   input  logic [7:0] op,
   input  logic [1:0] cs,
   output logic [1:0] sync_sig,
   output logic       legal
);

   logic is_sync;
   assign is_sync  = (op == OP_SYNC);
   assign sync_sig = is_sync ? cs : 2'd0;

   if (STRICT_SYNC) begin : g_strict
      assign legal = op_supported(op) && !(is_sync && cs == 2'd3);
   end else begin : g_lax
      assign legal = op_supported(op);
   end

endmodule

// File: rtl/cr_fetch.sv
module cr_fetch
   import cmd_ring_pkg::*;
#(
   parameter int unsigned ADDR_W      = 52,
   parameter int unsigned ENTRY_WORDS = 4,
   localparam int unsigned WI_W       = $clog2(ENTRY_WORDS),
   localparam int unsigned CMD_W      = 32 * ENTRY_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_ok,
   input  logic [ADDR_W-1:0] entry_addr,
   input  logic              legal,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_data,
   input  logic              mem_rsp_err,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [CMD_W-1:0]  cmd_words,
   output logic              cons_inc,
   output logic              err_set,
   output cerr_e             err_code,
   output logic              idle
);

   typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_AWAIT, S_PRESENT} fst_e;

   localparam logic [WI_W-1:0] LAST_W = WI_W'(ENTRY_WORDS - 1);

   fst_e              state_q;
   logic [WI_W-1:0]   widx_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CMD_W-1:0]  words_q;
   logic              last_rsp;

   assign last_rsp      = (widx_q == LAST_W);
   assign mem_req_valid = (state_q == S_ISSUE);
   assign mem_req_addr  = addr_q + ADDR_W'({widx_q, 2'b00});
   assign cmd_valid     = (state_q == S_PRESENT);
   assign cmd_words     = words_q;
   assign cons_inc      = (state_q == S_PRESENT) && cmd_ready;
   assign idle          = (state_q == S_IDLE);

   always_comb begin
      err_set  = 1'b0;
      err_code = CERR_NONE;
      if (state_q == S_AWAIT && mem_rsp_valid) begin
         if (mem_rsp_err) begin
            err_set  = 1'b1;
            err_code = CERR_ABORT;
         end else if (last_rsp && !legal) begin
            err_set  = 1'b1;
            err_code = CERR_ILLEGAL;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         widx_q  <= '0;
         addr_q  <= '0;
         words_q <= '0;
      end else begin
         unique case (state_q)
            S_IDLE: if (start_ok) begin
               addr_q  <= entry_addr;
               widx_q  <= '0;
               state_q <= S_ISSUE;
            end
            S_ISSUE: if (mem_req_ready) state_q <= S_AWAIT;
            S_AWAIT: if (mem_rsp_valid) begin
               if (mem_rsp_err) begin
                  state_q <= S_IDLE;
               end else begin
                  words_q[32*widx_q +: 32] <= mem_rsp_data;
                  if (!last_rsp) begin
                     widx_q  <= widx_q + WI_W'(1);
                     state_q <= S_ISSUE;
                  end else begin
                     state_q <= legal ? S_PRESENT : S_IDLE;
                  end
               end
            end
            S_PRESENT: if (cmd_ready) state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cmd_ring_ctrl.sv
module cmd_ring_ctrl
   import cmd_ring_pkg::*;
#(
   parameter int unsigned MAX_LOG2    = 4,
   parameter int unsigned ADDR_W      = 52,
   parameter int unsigned ENTRY_WORDS = 4,
   parameter bit          STRICT_SYNC = 1'b1,
   localparam int unsigned CMD_W       = 32 * ENTRY_WORDS,
   localparam int unsigned ENTRY_SHIFT = $clog2(ENTRY_WORDS * 4)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [63:0]       reg_wdata,
   input  logic [1:0]        rd_sel,
   output logic [63:0]       rd_data,
   output logic              ring_empty,
   output logic              ring_full,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_data,
   input  logic              mem_rsp_err,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [7:0]        cmd_opcode,
   output logic [1:0]        cmd_sync,
   output logic [CMD_W-1:0]  cmd_words
);

   if (MAX_LOG2 < 1 || MAX_LOG2 > 19) begin : g_bad_log2
      $error("MAX_LOG2 must keep index and wrap bit below the error field");
   end
   if (ADDR_W < 16 || ADDR_W > 60) begin : g_bad_addr
      $error("ADDR_W out of supported range");
   end
   if (ENTRY_WORDS < 2 || (ENTRY_WORDS & (ENTRY_WORDS - 1)) != 0) begin : g_bad_words
      $error("ENTRY_WORDS must be a power of two of at least 2");
   end

   logic [31:0]       prod_q;
   logic [31:0]       cons_q;
   logic [31:0]       wi_mask;
   logic              ctrl_en;
   logic [ERR_W-1:0]  err_code;
   logic [ADDR_W-1:0] entry_addr;
   logic              cons_inc;
   logic              err_set;
   cerr_e             err_code_new;
   logic              legal;
   logic              fetch_idle;
   logic              start_ok;

   assign start_ok   = ctrl_en && !ring_empty && (err_code == '0);
   assign cmd_opcode = cmd_words[7:0];

   cr_regs #(
      .MAX_LOG2   (MAX_LOG2),
      .ADDR_W     (ADDR_W),
      .ENTRY_SHIFT(ENTRY_SHIFT)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_sel    (reg_sel),
      .reg_wdata  (reg_wdata),
      .rd_sel     (rd_sel),
      .rd_data    (rd_data),
      .cons_inc   (cons_inc),
      .err_set    (err_set),
      .err_code_in(err_code_new),
      .prod_q     (prod_q),
      .cons_q     (cons_q),
      .wi_mask    (wi_mask),
      .ctrl_en    (ctrl_en),
      .err_code   (err_code),
      .ring_empty (ring_empty),
      .ring_full  (ring_full),
      .entry_addr (entry_addr)
   );

   cr_fetch #(
      .ADDR_W     (ADDR_W),
      .ENTRY_WORDS(ENTRY_WORDS)
   ) u_fetch (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_ok     (start_ok),
      .entry_addr   (entry_addr),
      .legal        (legal),
      .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready),
      .mem_req_addr (mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data),
      .mem_rsp_err  (mem_rsp_err),
      .cmd_valid    (cmd_valid),
      .cmd_ready    (cmd_ready),
      .cmd_words    (cmd_words),
      .cons_inc     (cons_inc),
      .err_set      (err_set),
      .err_code     (err_code_new),
      .idle         (fetch_idle)
   );

   cr_decode #(
      .STRICT_SYNC(STRICT_SYNC)
   ) u_decode (
      .op      (cmd_words[7:0]),
      .cs      (cmd_words[13:12]),
      .sync_sig(cmd_sync),
      .legal   (legal)
   );

endmodule

// File: rtl/cmd_ring_chk.sv
module cmd_ring_chk #(
   parameter int unsigned CMD_W = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic             fetch_idle,
   input logic             ring_empty,
   input logic             ring_full,
   input logic             ctrl_en,
   input logic [6:0]       err_code,
   input logic [31:0]      cons_q,
   input logic [31:0]      wi_mask,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic [CMD_W-1:0] cmd_words
);

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ring_full && ring_empty)); // R3

   AST_NO_START_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_idle && ring_empty && !reg_we) |=> fetch_idle); // R2

   AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_idle && !ctrl_en && !reg_we) |=> fetch_idle); // R5

   AST_HALT_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_idle && err_code != 7'd0 && !reg_we) |=> fetch_idle); // R8

   AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_words))); // R6

   AST_CONS_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && !reg_we)
      |=> ((cons_q & ~wi_mask) == ($past(cons_q) & ~$past(wi_mask)))); // R7

endmodule

bind cmd_ring_ctrl cmd_ring_chk #(.CMD_W(CMD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .fetch_idle(fetch_idle),
   .ring_empty(ring_empty),
   .ring_full (ring_full),
   .ctrl_en   (ctrl_en),
   .err_code  (err_code),
   .cons_q    (cons_q),
   .wi_mask   (wi_mask),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_words (cmd_words)
);

// File: tb/test_cmd_ring_ctrl.sv
`timescale 1ns/1ps
module test_cmd_ring_ctrl;

   localparam int unsigned MAX_LOG2 = 4;
   localparam int unsigned ADDR_W   = 52;
   localparam logic [51:0] BASE     = 52'h0_0000_1234_5600;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_we = 1'b0;
   logic [1:0]        reg_sel = 2'd0;
   logic [63:0]       reg_wdata = '0;
   logic [1:0]        rd_sel = 2'd0;
   logic [63:0]       rd_data;
   logic              ring_empty, ring_full;
   logic              mem_req_valid;
   logic              mem_req_ready = 1'b1;
   logic [ADDR_W-1:0] mem_req_addr;
   logic              mem_rsp_valid = 1'b0;
   logic [31:0]       mem_rsp_data = '0;
   logic              mem_rsp_err = 1'b0;
   logic              cmd_valid;
   logic              cmd_ready = 1'b0;
   logic [7:0]        cmd_opcode;
   logic [1:0]        cmd_sync;
   logic [127:0]      cmd_words;

   int n_checks = 0;
   int n_errors = 0;

   logic [31:0]       mem [0:63];
   logic [51:0]       req_log [0:15];
   int                req_cnt = 0;
   logic              abort_en = 1'b0;
   logic [51:0]       abort_off = '0;
   logic [51:0]       off;

   always #2 clk = ~clk;

   cmd_ring_ctrl #(.MAX_LOG2(MAX_LOG2), .ADDR_W(ADDR_W)) i_cmd_ring_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
      .ring_empty(ring_empty), .ring_full(ring_full),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
      .cmd_sync(cmd_sync), .cmd_words(cmd_words)
   );

   // Memory model: answers each accepted request one cycle later.
   always @(posedge clk) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
         off = (mem_req_addr - BASE) >> 2;
         mem_rsp_valid <= 1'b1;
         mem_rsp_data  <= mem[off[5:0]];
         mem_rsp_err   <= abort_en && (off == abort_off);
         req_log[req_cnt & 15] = mem_req_addr;
         req_cnt = req_cnt + 1;
      end
   end

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [63:0] data);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [63:0] val);
      @(negedge clk);
      rd_sel = sel;
      #1 val = rd_data;
   endtask

   task automatic put_cmd(input int slot, input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3);
      mem[slot*4+0] = w0; mem[slot*4+1] = w1;
      mem[slot*4+2] = w2; mem[slot*4+3] = w3;
   endtask

   task automatic wait_cmd(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (cmd_valid) begin seen = 1'b1; break; end
      end
   endtask

   task automatic accept();
      @(negedge clk); cmd_ready = 1'b1;
      @(negedge clk); cmd_ready = 1'b0;
   endtask

   task automatic setup(input logic [4:0] lg);
      wr(2'd3, 64'd0);
      wr(2'd0, 64'(BASE) | 64'h20 | 64'(lg));   // bit 5 is junk, must be masked
   endtask

   task automatic t_reset();
      logic [63:0] v;
      rd(2'd1, v); check("R1 prod", v, 0);
      rd(2'd2, v); check("R1 cons", v, 0);
      check("R1 empty", ring_empty, 1);
      check("R1 full", ring_full, 0);
      check("R1 cmd_valid", cmd_valid, 0);
      check("R1 mem_req_valid", mem_req_valid, 0);
   endtask

   task automatic t_flags();
      setup(5'd2);
      wr(2'd1, 64'd5);    wr(2'd2, 64'd1);
      @(negedge clk); check("R3 full wrap only", {ring_full, ring_empty}, 2'b10);
      wr(2'd1, 64'h13);   wr(2'd2, 64'd3);
      @(negedge clk); check("R2 empty upper ignored", {ring_full, ring_empty}, 2'b01);
      wr(2'd1, 64'd2);    wr(2'd2, 64'd1);
      @(negedge clk); check("R2 R3 partial", {ring_full, ring_empty}, 2'b00);
   endtask

   task automatic t_basic();
      bit seen;
      logic [63:0] v;
      setup(5'd2);
      put_cmd(0, 32'h0000_3003, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333);
      put_cmd(1, 32'h0000_1046, 32'hA1, 32'hA2, 32'hA3);
      wr(2'd2, 64'd0); wr(2'd1, 64'd2);
      req_cnt = 0;
      wr(2'd3, 64'h8);
      wait_cmd(seen);
      check("R6 first valid", seen, 1);
      check("R4 req count", req_cnt, 4);
      for (int k = 0; k < 4; k++) check("R4 word addr", req_log[k], BASE + 52'(4*k));
      check("R6 opcode", cmd_opcode, 8'h03);
      check("R6 sync non-sync op", cmd_sync, 2'd0);
      check("R6 words", cmd_words, {32'h3333_3333, 32'h2222_2222, 32'h1111_1111, 32'h0000_3003});
      repeat (3) @(negedge clk);
      check("R6 held", {cmd_valid, cmd_words[31:0]}, {1'b1, 32'h0000_3003});
      accept();
      rd(2'd2, v); check("R7 cons after first", v, 1);
      wait_cmd(seen);
      check("R6 second valid", seen, 1);
      check("R4 second entry", req_log[4], BASE + 52'd16);
      check("R6 sync opcode", cmd_opcode, 8'h46);
      check("R6 sync interrupt", cmd_sync, 2'd1);
      accept();
      rd(2'd2, v); check("R7 cons after second", v, 2);
      check("R2 drained", ring_empty, 1);
      wr(2'd3, 64'd0);
   endtask

   task automatic t_wrap();
      bit seen;
      logic [63:0] v;
      setup(5'd1);
      put_cmd(1, 32'h0000_0010, 32'h5, 32'h6, 32'h7);
      wr(2'd2, 64'h0080_0003); wr(2'd1, 64'd0);
      req_cnt = 0;
      wr(2'd3, 64'h8);
      wait_cmd(seen);
      check("R4 index uses low bits", {seen, req_log[0]}, {1'b1, BASE + 52'd16});
      check("R6 opcode wrap", cmd_opcode, 8'h10);
      accept();
      rd(2'd2, v); check("R7 wrap keeps upper", v, 64'h0080_0000);
      check("R2 empty after wrap", ring_empty, 1);
      wr(2'd3, 64'd0);
   endtask

   task automatic t_disabled();
      bit seen;
      logic [63:0] v;
      setup(5'd2);
      put_cmd(0, 32'h0000_0001, 0, 0, 0);
      wr(2'd2, 64'd0); wr(2'd1, 64'd1);
      req_cnt = 0;
      wr(2'd3, 64'h7);
      repeat (20) @(negedge clk);
      check("R5 no fetch when disabled", {req_cnt[7:0], cmd_valid}, 9'd0);
      wr(2'd3, 64'h8);
      wait_cmd(seen);
      check("R5 fetch once enabled", {seen, cmd_opcode}, {1'b1, 8'h01});
      accept();
      rd(2'd2, v); check("R7 cons after enable", v, 1);
      wr(2'd3, 64'd0);
   endtask

   task automatic t_illegal();
      bit seen;
      logic [63:0] v;
      setup(5'd2);
      put_cmd(0, 32'h0000_0008, 0, 0, 0);
      put_cmd(1, 32'h0000_0020, 0, 0, 0);
      wr(2'd2, 64'd0); wr(2'd1, 64'd2);
      req_cnt = 0;
      wr(2'd3, 64'h8);
      repeat (25) @(negedge clk);
      rd(2'd2, v); check("R8 illegal code", v, 64'h0100_0000);
      check("R8 halted", {req_cnt[7:0], cmd_valid}, {8'd4, 1'b0});
      put_cmd(0, 32'h0000_3046, 0, 0, 0);
      wr(2'd2, 64'd0);
      repeat (25) @(negedge clk);
      rd(2'd2, v); check("R8 sync field 3 illegal", v, 64'h0100_0000);
      check("R10 refetched once", req_cnt, 8);
      put_cmd(0, 32'h0000_0046, 0, 0, 0);
      wr(2'd2, 64'd0);
      wait_cmd(seen);
      check("R10 resumed", {seen, cmd_opcode, cmd_sync}, {1'b1, 8'h46, 2'd0});
      accept();
      wait_cmd(seen);
      check("R10 next entry", {seen, cmd_opcode}, {1'b1, 8'h20});
      accept();
      rd(2'd2, v); check("R10 cons advanced", v, 2);
      wr(2'd3, 64'd0);
   endtask

   task automatic t_abort();
      bit seen;
      logic [63:0] v;
      setup(5'd2);
      put_cmd(0, 32'h0000_0001, 0, 0, 0);
      wr(2'd2, 64'd0); wr(2'd1, 64'd1);
      abort_en = 1'b1; abort_off = 52'd2;
      req_cnt = 0;
      wr(2'd3, 64'h8);
      repeat (25) @(negedge clk);
      rd(2'd2, v); check("R9 abort code", v, 64'h0200_0000);
      check("R9 stopped", {req_cnt[7:0], cmd_valid}, {8'd3, 1'b0});
      abort_en = 1'b0;
      wr(2'd2, 64'd0);
      wait_cmd(seen);
      check("R10 after abort", {seen, cmd_opcode}, {1'b1, 8'h01});
      accept();
      rd(2'd2, v); check("R7 cons after abort retry", v, 1);
      wr(2'd3, 64'd0);
   endtask

   task automatic t_clamp();
      logic [63:0] v;
      setup(5'd31);
      rd(2'd0, v); check("R11 base readback clamped", v, 64'(BASE) | 64'd4);
      wr(2'd2, 64'd0); wr(2'd1, 64'h10);
      @(negedge clk); check("R11 full at clamped size", {ring_full, ring_empty}, 2'b10);
      wr(2'd1, 64'h20);
      @(negedge clk); check("R11 bit above wrap ignored", {ring_full, ring_empty}, 2'b01);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_flags();
      t_basic();
      t_wrap();
      t_disabled();
      t_illegal();
      t_abort();
      t_clamp();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule